// File: doc/BRIEF.md
# Two-Level Operand Stack Cache

This block holds the operand stack of a stack-machine execution core. The two topmost entries sit in two registers. The ALU reads both of them at once and without delay: `tos_o` is the top of stack and `nos_o` is the entry below it. Every deeper entry lives in a dual-port on-chip RAM that can be inferred as block RAM. A push spills the lower register into the RAM. A pop refills it from the RAM. Variable loads and stores reach RAM words relative to a frame base register.

The block registers each decoded operation on `op_i` into an internal execute slot. In the same cycle it presents the RAM read address that this operation will need. The read data is therefore waiting when the operation executes one cycle later, so back-to-back operations in any order run without stalls and without forwarding muxes. An external ALU computes from `tos_o` and `nos_o` and returns its result on `alu_y_i`. The block writes that result back as the new top of stack. The register pair always counts as occupied. `depth_o` reports how many words are held in the RAM. A push into a full RAM raises a sticky overflow flag.

Top module: `opstack_cache`

## Requirements
- R1: After synchronous reset, `tos_o` and `nos_o` are zero, `depth_o` is zero and `ovf_o` is low.
- R2: An operation on `op_i` is sampled at one rising edge and executes at the next. Its effect is visible on the outputs after that second edge. One operation is accepted every cycle.
- R3: Push (`op_i`=1, when not full): the old `nos_o` is written to RAM word `depth_o`, `nos_o` takes the old `tos_o`, `tos_o` takes `din_i`, and `depth_o` increases by one.
- R4: Pop (`op_i`=2): `tos_o` takes the old `nos_o`, `nos_o` is refilled from RAM word `depth_o`-1, and `depth_o` decreases by one.
- R5: Binary operation (`op_i`=3): `tos_o` takes `alu_y_i` as sampled in the execute cycle, where the ALU sees the current `tos_o` and `nos_o`. `nos_o` is refilled from RAM word `depth_o`-1, and `depth_o` decreases by one.
- R6: Variable load (`op_i`=4): behaves as a push whose value is RAM word (frame base + `idx_i`) modulo DEPTH. The word is read before this operation's own spill.
- R7: Variable store (`op_i`=5): writes `tos_o` to RAM word (frame base + `idx_i`), then pops as in R4. A variable load directly after it returns the stored value.
- R8: Set frame base (`op_i`=6): the frame base takes the low address bits of `din_i`. `tos_o`, `nos_o` and `depth_o` are unchanged.
- R9: A push or variable load while `depth_o` equals DEPTH sets `ovf_o`. `ovf_o` then stays high until reset, and the stack is left unchanged. `depth_o` never exceeds DEPTH.
- R10: A push followed in the very next cycle by a pop returns the spilled value to `nos_o`.
- R11: Codes 0 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Decoded stack operation code |
| din_i | input | DW | Push value or new frame base |
| idx_i | input | log2(DEPTH) | Variable index relative to the frame base |
| alu_y_i | input | DW | ALU result for a binary operation |
| tos_o | output | DW | Top of stack (register A) |
| nos_o | output | DW | Entry below the top (register B) |
| depth_o | output | log2(DEPTH)+1 | Number of words held in the RAM |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench goes after the read-during-write cases. A pop right after a push, and a variable load right after a store to the same word, both need the value written at the same edge. A RAM that returns its old content would hand back a stale `nos_o` or a stale loaded variable. The bench also fills the RAM to exactly DEPTH words and then pushes twice more. A design that is off by one would either flag overflow early, or wrap and corrupt the lowest word, and a later pop would expose that. Binary-operation chains check that the ALU result lands in TOS while NOS is refilled from the RAM. A design that mixed up the refill address would show the wrong deeper value.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_BIN   = 3'd3,
    OP_LDV   = 3'd4,
    OP_STV   = 3'd5,
    OP_SETVP = 3'd6,
    OP_RSV   = 3'd7
  } stk_op_e;

  function automatic logic op_grows(stk_op_e o);
    return (o == OP_PUSH) || (o == OP_LDV);
  endfunction

  function automatic logic op_shrinks(stk_op_e o);
    return (o == OP_POP) || (o == OP_BIN) || (o == OP_STV);
  endfunction
endpackage

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port; a same-address collision
  // returns the word being written (write-first)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end
endmodule

// File: rtl/sc_ptr.sv
module sc_ptr
  import opstack_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       ex_op,
  input  logic [AW-1:0] ex_base,
  input  logic [AW-1:0] ex_idx,
  input  stk_op_e       nx_op,
  input  logic [AW-1:0] nx_idx,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          push_ok,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic          wr_store,
  output logic [AW-1:0] wr_addr
);
  logic [AW-1:0] vp, vp_nx;
  logic [CW-1:0] cnt_nx;
  logic          full;

  always_comb begin
    full     = (cnt == CW'(DEPTH));
    push_ok  = op_grows(ex_op) && !full;
    wr_store = (ex_op == OP_STV);
    wr_en    = push_ok || wr_store;
    wr_addr  = wr_store ? AW'(vp + ex_idx) : cnt[AW-1:0];

    if (push_ok)                                 cnt_nx = cnt + CW'(1);
    else if (op_shrinks(ex_op) && cnt != '0)     cnt_nx = cnt - CW'(1);
    else                                         cnt_nx = cnt;

    vp_nx = (ex_op == OP_SETVP) ? ex_base : vp;

    // address for the operation that executes next cycle
    if (nx_op == OP_LDV) rd_addr = AW'(vp_nx + nx_idx);
    else                 rd_addr = AW'(cnt_nx - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      vp  <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      vp  <= vp_nx;
      if (op_grows(ex_op) && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
  import opstack_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       ex_op,
  input  logic          push_ok,
  input  logic [DW-1:0] ex_din,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (push_ok) begin
      reg_b <= reg_a;
      reg_a <= (ex_op == OP_LDV) ? rdata : ex_din;
    end else if (op_shrinks(ex_op)) begin
      reg_a <= (ex_op == OP_BIN) ? alu_y : reg_b;
      reg_b <= rdata;
    end
  end
endmodule

// File: rtl/opstack_cache.sv
module opstack_cache
  import opstack_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] din_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] alu_y_i,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] nos_o,
  output logic [CW-1:0] depth_o,
  output logic          ovf_o
);
  stk_op_e       nx_op, ex_op;
  logic [DW-1:0] ex_din;
  logic [AW-1:0] ex_idx;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en, wr_store, push_ok;
  logic [DW-1:0] rdata, wdata;

  assign nx_op = stk_op_e'(op_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_op  <= OP_NOP;
      ex_din <= '0;
      ex_idx <= '0;
    end else begin
      ex_op  <= nx_op;
      ex_din <= din_i;
      ex_idx <= idx_i;
    end
  end

  sc_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .ex_op(ex_op), .ex_base(ex_din[AW-1:0]),
    .ex_idx(ex_idx), .nx_op(nx_op), .nx_idx(idx_i), .cnt(depth_o),
    .ovf(ovf_o), .push_ok(push_ok), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_store(wr_store), .wr_addr(wr_addr)
  );

  assign wdata = wr_store ? tos_o : nos_o;

  sc_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  sc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .ex_op(ex_op), .push_ok(push_ok),
    .ex_din(ex_din), .alu_y(alu_y_i), .rdata(rdata),
    .reg_a(tos_o), .reg_b(nos_o)
  );
endmodule

// File: rtl/opstack_cache_chk.sv
module opstack_cache_chk
  import opstack_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input stk_op_e       ex_op,
  input logic [DW-1:0] tos,
  input logic [DW-1:0] nos,
  input logic [CW-1:0] depth,
  input logic          ovf
);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));
  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_PUSH && depth == CW'(DEPTH)) |=> (ovf && $stable(tos) && $stable(nos) && $stable(depth)));
  // R3
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_PUSH && depth != CW'(DEPTH)) |=> (nos == $past(tos) && depth == $past(depth) + CW'(1)));
  // R4
  pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_POP && depth != '0) |=> (tos == $past(nos) && depth == $past(depth) - CW'(1)));
  // R8
  setvp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_SETVP) |=> ($stable(tos) && $stable(nos) && $stable(depth)));
endmodule

bind opstack_cache opstack_cache_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ex_op(ex_op), .tos(tos_o), .nos(nos_o),
  .depth(depth_o), .ovf(ovf_o)
);

// File: tb/sim_opstack_cache.sv
module sim_opstack_cache;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = 3'd0;
  logic [DW-1:0] din_i = '0;
  logic [AW-1:0] idx_i = '0;
  logic [DW-1:0] alu_y_i;
  logic [DW-1:0] tos_o, nos_o;
  logic [CW-1:0] depth_o;
  logic          ovf_o;

  always #10 clk = ~clk;

  // external ALU: addition
  assign alu_y_i = tos_o + nos_o;

  opstack_cache #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .din_i(din_i), .idx_i(idx_i),
    .alu_y_i(alu_y_i), .tos_o(tos_o), .nos_o(nos_o), .depth_o(depth_o),
    .ovf_o(ovf_o)
  );

  int tests = 0, fails = 0, edges = 0;
  bit finished = 0;
  always @(posedge clk) edges++;

  // reference model
  logic [DW-1:0] m_ram [DEPTH];
  logic [DW-1:0] m_a = '0, m_b = '0;
  int            m_cnt = 0, m_vp = 0;
  logic          m_ovf = 1'b0;

  // scoreboard queues
  int            q_due[$];
  logic [DW-1:0] q_a[$], q_b[$];
  int            q_cnt[$];
  logic          q_ovf[$];
  string         q_tag[$];

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic do_op(input int o, input logic [DW-1:0] d, input int ix, input string tag);
    logic [DW-1:0] rv;
    @(negedge clk);
    op_i = 3'(o); din_i = d; idx_i = AW'(ix);
    case (o)
      1, 4: begin
        rv = m_ram[(m_vp + ix) % DEPTH];
        if (m_cnt == DEPTH) m_ovf = 1'b1;
        else begin
          m_ram[m_cnt] = m_b; m_cnt++; m_b = m_a;
          m_a = (o == 1) ? d : rv;
        end
      end
      2, 3, 5: begin
        if (o == 5) m_ram[(m_vp + ix) % DEPTH] = m_a;
        m_a = (o == 3) ? m_a + m_b : m_b;
        m_b = m_ram[m_cnt - 1];
        m_cnt--;
      end
      6: m_vp = int'(d) % DEPTH;
      default: ;
    endcase
    q_due.push_back(edges + 2);
    q_a.push_back(m_a); q_b.push_back(m_b); q_cnt.push_back(m_cnt);
    q_ovf.push_back(m_ovf); q_tag.push_back(tag);
  endtask

  // monitor: compare outputs a quarter period after the due edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q_due.size() != 0 && q_due[0] == edges) begin
        logic [DW-1:0] ea, eb; int ec; logic eo; string t;
        ea = q_a.pop_front(); eb = q_b.pop_front(); ec = q_cnt.pop_front();
        eo = q_ovf.pop_front(); t = q_tag.pop_front(); void'(q_due.pop_front());
        tests++;
        if (tos_o !== ea || nos_o !== eb || int'(depth_o) != ec || ovf_o !== eo) begin
          fails++;
          $display("FAIL %s: tos=%0h nos=%0h depth=%0d ovf=%0b expected tos=%0h nos=%0h depth=%0d ovf=%0b",
                   t, tos_o, nos_o, depth_o, ovf_o, ea, eb, ec, eo);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    tests++;
    if (tos_o !== '0 || nos_o !== '0 || depth_o !== '0 || ovf_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: tos=%0h nos=%0h depth=%0d ovf=%0b expected all zero", tos_o, nos_o, depth_o, ovf_o);
    end
    // R2/R3: back-to-back pushes, spilling into the RAM
    for (int i = 1; i <= 5; i++) do_op(1, DW'(i * 10), 0, "R3");
    // R5: binary operations with refill
    do_op(3, '0, 0, "R5");
    do_op(3, '0, 0, "R5");
    // R8: frame base set, stack untouched
    do_op(6, 32'd1, 0, "R8");
    // R7 then R6 on the same word in the next cycle
    do_op(5, '0, 0, "R7");
    do_op(4, '0, 0, "R6");
    // R10: push then pop immediately
    do_op(1, 32'd77, 0, "R10");
    do_op(2, '0, 0, "R10");
    // R11: idle codes
    do_op(0, 32'hdead, 3, "R11");
    // R4: plain pop
    do_op(2, '0, 0, "R4");
    // R9: fill to DEPTH, then two more pushes
    for (int i = 0; i < DEPTH - 2; i++) do_op(1, DW'(100 + i), 0, "R3");
    do_op(1, 32'h55, 0, "R9");
    do_op(4, '0, 2, "R9");
    do_op(2, '0, 0, "R9");
    do_op(7, 32'hbeef, 1, "R11");
    do_op(2, '0, 0, "R4");
    @(negedge clk); op_i = 3'd0;
    while (q_due.size() != 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule